// File: doc/BRIEF.md
# One-Shot Event Timer

This block is a single-channel countdown timer. It has two 32-bit registers on a plain synchronous register bus. It runs straight off the system clock with no prescaler. Software arms it in three steps: it turns the timer on, loads a tick count into the value register, and then turns on the interrupt as well. Once armed, the count falls by one on every clock. When it reaches zero it stays there and raises a pending flag. The interrupt line is that pending flag gated by the interrupt-enable bit.

Software acknowledges an event through a clear strobe in the control register. The strobe is honoured only when it is written together with the run bit. A full reset of the channel takes three writes: the clear together with the run bit, then zero to the value register, then zero to the control register. After that the timer is idle, and no stale count can raise an interrupt later. The block is meant to serve as a wake-up or tick source that stays powered. Tick counts range from 3 to 0xFFFFFFFF.

Top module: `tick_event_timer`

## Requirements
- R1: After reset, the control register (offset 0x0) and the value register (offset 0x4) both read 0, and `irqOut` is low.
- R2: A write to offset 0x4 loads the count into the value register at that clock edge. A load takes priority over a decrement in the same cycle. The value register reads back the live count.
- R3: While the run bit (control bit 0) is 1 and the count is non-zero, the count decreases by exactly one per clock. When the count is 0 it stays at 0.
- R4: The pending flag is set at the edge where the count steps from 1 to 0 while running. It then stays set until it is cleared, including after the timer is stopped.
- R5: `irqOut` is high exactly when the pending flag is set and the interrupt-enable bit (control bit 1) is 1.
- R6: Writing control bit 4 together with bit 0 clears the pending flag. Writing bit 4 without bit 0 leaves the pending flag unchanged. Bit 4 always reads back as 0.
- R7: Writing 0 to control bit 0 freezes the count at its value after that edge.
- R8: After the sequence of control 0x11, value 0, control 0, the timer is idle. Re-enabling it with control 0x3 never raises `irqOut`.
- R9: All 32 bits of a loaded count are kept, including 0xFFFFFFFF. Writes to offsets other than 0x0 and 0x4 change nothing, and such offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rstN | input | 1 | active-low synchronous reset |
| regWrite | input | 1 | write strobe for the addressed register |
| regAddr | input | 4 | byte offset of the register |
| regWdata | input | 32 | write data |
| regRdata | output | 32 | read data for `regAddr` (combinational) |
| irqOut | output | 1 | event interrupt |

## Verification
A register write takes effect at the clock edge that captures it. The control and value fields can therefore be read back right after that edge, and read data is combinational from the address. A count loaded at edge B reads N−k after edge B+k. The pending flag and `irqOut` rise after edge B+N, with no extra pipeline stage. The bench samples at the falling edge after each write and after each single-cycle step. It compares the value register and `irqOut` against a count it keeps itself, so every check lands on the cycle that the requirement predicts.

// File: rtl/tick_event_timer_pkg.sv
package tick_event_timer_pkg;
  localparam int CTRL_OFF  = 0;
  localparam int VALUE_OFF = 4;
  localparam int RUN_BIT   = 0;
  localparam int IE_BIT    = 1;
  localparam int CLR_BIT   = 4;

  typedef struct packed {
    logic load;     // value register write this cycle
    logic countEn;  // timer is running
  } tmrStrobes_t;
endpackage

// File: rtl/tick_event_timer_ctrl.sv
module tick_event_timer_ctrl
  import tick_event_timer_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic        wrRun,
  input  logic        wrIe,
  input  logic        wrClr,
  input  logic        expire,
  output tmrStrobes_t strobes,
  output logic        runEn,
  output logic        irqEn,
  output logic        irqOut
);
  localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_OFF);
  localparam logic [ADDR_W-1:0] VALUE_A = ADDR_W'(VALUE_OFF);

  logic ctrlWr, clrHit, pending;

  assign ctrlWr = regWrite && (regAddr == CTRL_A);
  assign clrHit = ctrlWr && wrClr && wrRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn   <= 1'b0;
      irqEn   <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (ctrlWr) begin
        runEn <= wrRun;
        irqEn <= wrIe;
      end
      if (clrHit)      pending <= 1'b0;
      else if (expire) pending <= 1'b1;
    end
  end

  assign strobes.load    = regWrite && (regAddr == VALUE_A);
  assign strobes.countEn = runEn;
  assign irqOut          = pending && irqEn;

  // R4: once set, pending holds until a valid clear
  a_r4_pending_hold: assert property (@(posedge clk) disable iff (!rstN)
    pending && !clrHit |=> pending);
  // R4: an expiry without a clear sets pending
  a_r4_expire_sets: assert property (@(posedge clk) disable iff (!rstN)
    expire && !clrHit |=> pending);
  // R6: a clear written with the run bit drops pending
  a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
    clrHit |=> !irqOut);
  // R7: a control write without the run bit stops counting next cycle
  a_r7_stop: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr && !wrRun |=> !strobes.countEn);
endmodule

// File: rtl/tick_event_timer_dp.sv
module tick_event_timer_dp
  import tick_event_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobes_t      strobes,
  input  logic [CNT_W-1:0] loadData,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic atZero;
  assign atZero = (count == '0);
  assign expire = strobes.countEn && !strobes.load && (count == ONE);

  always_ff @(posedge clk) begin
    if (!rstN)                         count <= '0;
    else if (strobes.load)             count <= loadData;
    else if (strobes.countEn && !atZero) count <= count - ONE;
  end

  // R3: one step down per running cycle
  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    strobes.countEn && !strobes.load && !atZero |=> count == $past(count) - ONE);
  // R3: zero is sticky without a load
  a_r3_zero_stop: assert property (@(posedge clk) disable iff (!rstN)
    atZero && !strobes.load |=> count == '0);
  // R7: frozen while stopped
  a_r7_freeze: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.countEn && !strobes.load |=> $stable(count));
  // R2: load wins
  a_r2_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> count == $past(loadData));
endmodule

// File: rtl/tick_event_timer.sv
module tick_event_timer
  import tick_event_timer_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut
);
  localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_OFF);
  localparam logic [ADDR_W-1:0] VALUE_A = ADDR_W'(VALUE_OFF);

  tmrStrobes_t       strobes;
  logic              runEn, irqEn, expire;
  logic [DATA_W-1:0] count;

  tick_event_timer_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
    .wrRun(regWdata[RUN_BIT]), .wrIe(regWdata[IE_BIT]), .wrClr(regWdata[CLR_BIT]),
    .expire(expire), .strobes(strobes), .runEn(runEn), .irqEn(irqEn),
    .irqOut(irqOut)
  );

  tick_event_timer_dp #(.CNT_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadData(regWdata),
    .count(count), .expire(expire)
  );

  always_comb begin
    regRdata = '0;
    if (regAddr == CTRL_A) begin
      regRdata[RUN_BIT] = runEn;
      regRdata[IE_BIT]  = irqEn;
    end else if (regAddr == VALUE_A) begin
      regRdata = count;
    end
  end
endmodule

// File: tb/tick_event_timer_test.sv
module tick_event_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrite = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqOut;

  int nCmp = 0, nBad = 0;
  bit finished = 0;

  tick_event_timer uut (.*);

  always #2.5 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    regWrite = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [31:0] ctrlWord(bit run, bit ie, bit clr);
    return {27'd0, clr, 2'd0, ie, run};
  endfunction

  task automatic fullReset();
    wr(4'h0, 32'h11); wr(4'h4, 32'h0); wr(4'h0, 32'h0);
  endtask

  // arm with N ticks; after this returns the count reads n-1
  task automatic arm(int unsigned n, bit ie);
    wr(4'h0, ctrlWord(1, 0, 0));
    wr(4'h4, n);
    wr(4'h0, ctrlWord(1, ie, 0));
  endtask

  task automatic runOut(string tag, int unsigned n, bit ie);
    logic [31:0] v;
    int unsigned exp = n - 1;
    while (1) begin
      rd(4'h4, v);
      check({tag, " count"}, v, exp);
      check({tag, " irq"}, {31'd0, irqOut}, {31'd0, ie && exp == 0});
      if (exp == 0) break;
      step(); exp--;
    end
    step(); rd(4'h4, v);
    check({tag, " R3 zero sticky"}, v, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nBad++; nCmp++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c;
    void'($urandom(32'd1234));
    repeat (3) step();
    rstN = 1'b1;
    @(negedge clk);
    rd(4'h0, v); check("R1 ctrl reset", v, 0);
    rd(4'h4, v); check("R1 value reset", v, 0);
    check("R1 irq reset", {31'd0, irqOut}, 0);

    // R2/R3/R4/R5 minimum count with interrupt enabled
    arm(3, 1); runOut("R4 n=3", 3, 1);
    step(); check("R4 pending holds", {31'd0, irqOut}, 1);
    wr(4'h0, 32'h0);
    wr(4'h0, 32'h2);
    check("R4 pending survives stop", {31'd0, irqOut}, 1);
    wr(4'h0, 32'h1);
    check("R5 irq masked", {31'd0, irqOut}, 0);
    // R6 clear without run ignored
    wr(4'h0, 32'h10); wr(4'h0, 32'h2);
    check("R6 clear ignored", {31'd0, irqOut}, 1);
    rd(4'h0, v); check("R6 ctrl readback", v, 32'h2);
    wr(4'h0, 32'h13);
    rd(4'h0, v); check("R6 clr reads 0", v, 32'h3);
    check("R6 clear works", {31'd0, irqOut}, 0);
    repeat (5) step();
    check("R8 no refire from zero", {31'd0, irqOut}, 0);

    // R7 freeze
    fullReset();
    arm(40, 1);
    repeat (4) step();
    rd(4'h4, c);
    wr(4'h0, 32'h2);
    rd(4'h4, v); check("R7 stop edge", v, c - 1);
    repeat (10) step();
    rd(4'h4, v); check("R7 frozen", v, c - 1);
    check("R7 no irq", {31'd0, irqOut}, 0);

    // R2 reload while running
    wr(4'h0, 32'h3); wr(4'h4, 32'd7);
    rd(4'h4, v); check("R2 reload", v, 7);

    // R8 reset sequence mid-count
    fullReset();
    rd(4'h4, v); check("R8 value cleared", v, 0);
    rd(4'h0, v); check("R8 ctrl cleared", v, 0);
    wr(4'h0, 32'h3);
    repeat (20) step();
    check("R8 idle no irq", {31'd0, irqOut}, 0);

    // R9 max count and unknown offset
    fullReset();
    wr(4'h0, 32'h1); wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, v); check("R9 max load", v, 32'hFFFF_FFFF);
    step(); rd(4'h4, v); check("R9 max step", v, 32'hFFFF_FFFE);
    wr(4'h8, 32'h5);
    rd(4'h4, v); check("R9 stray write", v, 32'hFFFF_FFFD);
    rd(4'h8, v); check("R9 stray read", v, 0);
    rd(4'h0, v); check("R9 ctrl intact", v, 1);

    // random runs
    for (int i = 0; i < 25; i++) begin
      int unsigned n = $urandom_range(3, 60);
      bit ie = 1'($urandom_range(0, 1));
      fullReset();
      arm(n, ie);
      runOut($sformatf("R3 R5 rand%0d", i), n, ie);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule